// File: doc/BRIEF.md
# Line-Code Balance and Run-Length Monitor

This block watches a stream of 10-bit line symbols, one per cycle when the valid strobe is high. It checks two transmission rules that keep a serial link usable for clock recovery. The first rule bounds DC imbalance: across the twenty line bits made of the newest symbol and the one before it, ones minus zeros must stay within plus or minus two. The second rule bounds runs: no more than five identical bits in a row. Bit 0 of each symbol is the first bit on the line, and a run that starts at the end of one symbol and carries on into the next counts as a single run.

The block is a passive monitor placed beside a transmitter or receiver datapath. After each accepted symbol it reports three things: a per-symbol violation pulse for each rule, a sticky copy of each pulse, and the current window disparity and run length. A clear-errors input drops the sticky flags. The same input restarts the balance check, so the check resumes only once a fresh pair of symbols has arrived. Two saturating counters tally accepted symbols and symbols that broke either rule.

Top module: `lcode_monitor`

## Requirements
- R1: After a cycle with rst_n low, every output is zero: flags, sticky flags, run_len, disparity, sym_count and viol_count.
- R2: Bits are consumed bit 0 first. run_len gives the length of the run of identical bits that ends at the last bit accepted. It carries across symbol boundaries and saturates at 15.
- R3: run_err is high in the cycle after a valid symbol during which some run reached 6 or more bits, including a run continued from the previous symbol. A run of exactly 5 does not raise it.
- R4: disparity is a signed 6-bit value holding ones minus zeros over the current and previous valid symbols. When no previous symbol has been accepted since reset or clear, it holds ones minus zeros of the current symbol alone.
- R5: disp_err is high in the cycle after a valid symbol whose 20-bit window disparity exceeds 2 in magnitude. This applies only when a previous symbol was accepted since the last reset or clear. A magnitude of exactly 2 passes.
- R6: In the cycle after sym_vld is low, run_err and disp_err are low, and run_len, disparity and both counters keep their values, whatever sym_data holds.
- R7: run_err_sticky and disp_err_sticky are set with their per-symbol flag and stay set until clr_err. If clr_err and a violating symbol arrive in the same cycle, the flag ends up set.
- R8: clr_err clears both sticky flags and forgets the previous symbol for the balance check. It leaves the run state untouched. A symbol accepted together with clr_err counts as the first after the clear.
- R9: sym_count counts valid symbols. viol_count counts valid symbols that broke either rule. Both are 16 bits and saturate at 65535.
- R10: The alternating pattern 0101010101 and the paired pattern 1100110011, sent alternately with its complement 0011001100, raise no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_vld | input | 1 | sym_data holds a symbol this cycle |
| sym_data | input | 10 | Line symbol, bit 0 sent first |
| clr_err | input | 1 | Clear sticky flags and restart balance check |
| run_err | output | 1 | Run-length violation for the last symbol |
| disp_err | output | 1 | Balance violation for the last symbol |
| run_err_sticky | output | 1 | Run violation seen since last clear |
| disp_err_sticky | output | 1 | Balance violation seen since last clear |
| run_len | output | 4 | Current run length, saturating |
| disparity | output | 6 | Signed window disparity of the last symbol |
| sym_count | output | 16 | Accepted symbols, saturating |
| viol_count | output | 16 | Violating symbols, saturating |

## Verification
Alternating and paired-complement symbol streams show that balanced, frequently toggling data passes both rules. A repeated paired symbol gives each symbol a disparity of +2 and the window +4, which separates the per-symbol and two-symbol windows. Two symbol pairs that each pass alone but join into runs of exactly 5 and exactly 6 across the boundary separate per-symbol run checking from stream-wide counting and pin the limit. All-zero symbols, idle cycles with junk on the data bus, and clears issued with and without a symbol show saturation, the first-symbol exemption, and the hold and clear behaviour.

// File: rtl/lcode_pkg.sv
// Shared types for the line-code monitor.
package lcode_pkg;
    // Per-symbol outcome of the two line rules
    typedef struct packed {
        logic run_bad;
        logic disp_bad;
    } viol_t;
endpackage

// File: rtl/lcode_sat_counter.sv
// Saturating up-counter.
// Assumes: inc is a single-cycle qualifier; count holds at all ones.
module lcode_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count up on inc, stop at TOP
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/lcode_run_tracker.sv
// Tracks the run of identical bits through the stream, bit 0 first.
// Flags a symbol when any run inside it (including one continued from the
// previous symbol) exceeds MAX_RUN. The counter saturates at 2**CNT_W-1.
// Assumes: MAX_RUN < 2**CNT_W-1 so saturation never hides a violation.
module lcode_run_tracker #(
    parameter int SYM_W   = 10,
    parameter int MAX_RUN = 5,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic [SYM_W-1:0] sym,
    output logic [CNT_W-1:0] run_len,
    output logic             hit
);
    localparam logic [CNT_W-1:0] SAT = '1;
    localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_RUN);

    logic             last_q;
    logic             last_n;
    logic [CNT_W-1:0] len_n;

    // Walk the symbol bit by bit, extending or restarting the run
    always_comb begin
        len_n  = run_len;
        last_n = last_q;
        hit    = 1'b0;
        for (int i = 0; i < SYM_W; i++) begin
            if (len_n != '0 && sym[i] == last_n) begin
                if (len_n != SAT)
                    len_n = len_n + 1'b1;
            end else begin
                len_n = CNT_W'(1);
            end
            last_n = sym[i];
            if (len_n > LIM)
                hit = 1'b1;
        end
    end

    // Keep run state across symbols and idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            last_q  <= 1'b0;
        end else if (vld) begin
            run_len <= len_n;
            last_q  <= last_n;
        end
    end
endmodule

// File: rtl/lcode_disp_window.sv
// Computes ones-minus-zeros over the current symbol plus the previous one.
// The previous symbol's part counts only once one was accepted since reset
// or clear; a clear in the same cycle as a symbol drops the old one.
// Assumes: DW bits hold +/- 2*SYM_W.
module lcode_disp_window #(
    parameter int SYM_W = 10,
    parameter int DW    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld,
    input  logic                 clr,
    input  logic [SYM_W-1:0]     sym,
    output logic signed [DW-1:0] win,
    output logic                 full
);
    localparam logic signed [DW-1:0] ONE = 1;

    logic signed [DW-1:0] cur_d;
    logic signed [DW-1:0] prev_q;
    logic                 have_q;

    // Disparity of the incoming symbol alone
    always_comb begin
        cur_d = '0;
        for (int i = 0; i < SYM_W; i++)
            cur_d = sym[i] ? cur_d + ONE : cur_d - ONE;
    end

    // Combine with the stored half of the window when it is valid
    always_comb begin
        full = have_q && !clr;
        win  = full ? cur_d + prev_q : cur_d;
    end

    // Remember the last symbol's disparity and whether it counts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (vld) begin
            prev_q <= cur_d;
            have_q <= 1'b1;
        end else if (clr) begin
            have_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lcode_monitor.sv
// Line-code monitor: checks a stream of symbols for DC balance over a
// two-symbol window and for the longest run of identical bits.
// Assumes: one symbol per cycle at most, bit 0 sent first; all outputs are
// registered and reflect the symbol accepted at the previous clock edge.
module lcode_monitor #(
    parameter  int SYM_W    = 10,
    parameter  int MAX_RUN  = 5,
    parameter  int DISP_LIM = 2,
    parameter  int RUN_W    = 4,
    parameter  int CNT_W    = 16,
    localparam int DW       = $clog2(2*SYM_W+1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sym_vld,
    input  logic [SYM_W-1:0]     sym_data,
    input  logic                 clr_err,
    output logic                 run_err,
    output logic                 disp_err,
    output logic                 run_err_sticky,
    output logic                 disp_err_sticky,
    output logic [RUN_W-1:0]     run_len,
    output logic signed [DW-1:0] disparity,
    output logic [CNT_W-1:0]     sym_count,
    output logic [CNT_W-1:0]     viol_count
);
    import lcode_pkg::*;

    localparam logic signed [DW-1:0] DLIM = DW'(DISP_LIM);

    logic                 run_hit;
    logic signed [DW-1:0] win;
    logic                 win_full;
    viol_t                viol;

    lcode_run_tracker #(.SYM_W(SYM_W), .MAX_RUN(MAX_RUN), .CNT_W(RUN_W)) u_run (
        .clk(clk), .rst_n(rst_n), .vld(sym_vld), .sym(sym_data),
        .run_len(run_len), .hit(run_hit)
    );

    lcode_disp_window #(.SYM_W(SYM_W), .DW(DW)) u_win (
        .clk(clk), .rst_n(rst_n), .vld(sym_vld), .clr(clr_err), .sym(sym_data),
        .win(win), .full(win_full)
    );

    // Qualify both rule results with the valid strobe
    always_comb begin
        viol.run_bad  = sym_vld && run_hit;
        viol.disp_bad = sym_vld && win_full && (win > DLIM || win < -DLIM);
    end

    // Register per-symbol flags, sticky flags and the reported disparity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_err         <= 1'b0;
            disp_err        <= 1'b0;
            run_err_sticky  <= 1'b0;
            disp_err_sticky <= 1'b0;
            disparity       <= '0;
        end else begin
            run_err         <= viol.run_bad;
            disp_err        <= viol.disp_bad;
            run_err_sticky  <= (run_err_sticky  && !clr_err) || viol.run_bad;
            disp_err_sticky <= (disp_err_sticky && !clr_err) || viol.disp_bad;
            if (sym_vld)
                disparity <= win;
        end
    end

    lcode_sat_counter #(.W(CNT_W)) u_sym_cnt (
        .clk(clk), .rst_n(rst_n), .inc(sym_vld), .count(sym_count)
    );

    lcode_sat_counter #(.W(CNT_W)) u_viol_cnt (
        .clk(clk), .rst_n(rst_n), .inc(viol.run_bad || viol.disp_bad),
        .count(viol_count)
    );
endmodule

// File: rtl/lcode_monitor_chk.sv
// Property checker for lcode_monitor, attached by bind below.
// Assumes: same parameters as the monitor it observes.
module lcode_monitor_chk #(
    parameter int RUN_W = 4,
    parameter int CNT_W = 16,
    parameter int DW    = 6,
    parameter int DISP_LIM = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sym_vld,
    input logic                 clr_err,
    input logic                 run_err,
    input logic                 disp_err,
    input logic                 run_err_sticky,
    input logic                 disp_err_sticky,
    input logic [RUN_W-1:0]     run_len,
    input logic signed [DW-1:0] disparity,
    input logic [CNT_W-1:0]     sym_count,
    input logic [CNT_W-1:0]     viol_count
);
    localparam logic signed [DW-1:0] DLIM = DW'(DISP_LIM);
    localparam logic [CNT_W-1:0]     CTOP = '1;

    assert_idle_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> (!run_err && !disp_err));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> ($stable(run_len) && $stable(disparity) && $stable(sym_count)));

    assert_run_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_err |-> run_err_sticky);

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_err_sticky && !clr_err) |=> run_err_sticky);

    assert_disp_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_err_sticky && !clr_err) |=> disp_err_sticky);

    assert_disp_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_err |-> (disparity > DLIM || disparity < -DLIM));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && sym_count != CTOP) |=> sym_count == $past(sym_count) + 1'b1);

    assert_viol_le_sym_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_count <= sym_count);
endmodule

bind lcode_monitor lcode_monitor_chk #(
    .RUN_W(RUN_W), .CNT_W(CNT_W), .DW(DW), .DISP_LIM(DISP_LIM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .clr_err(clr_err),
    .run_err(run_err), .disp_err(disp_err),
    .run_err_sticky(run_err_sticky), .disp_err_sticky(disp_err_sticky),
    .run_len(run_len), .disparity(disparity),
    .sym_count(sym_count), .viol_count(viol_count)
);

// File: tb/lcode_monitor_tb.sv
// Directed bench for lcode_monitor; expected values come from a
// requirement-level model of the two line rules.
module lcode_monitor_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sym_vld = 1'b0;
    logic [9:0]        sym_data = '0;
    logic              clr_err = 1'b0;
    logic              run_err, disp_err, run_err_sticky, disp_err_sticky;
    logic [3:0]        run_len;
    logic signed [5:0] disparity;
    logic [15:0]       sym_count, viol_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected state
    int m_last, m_run, m_prev, m_disp, m_sc, m_vc;
    bit m_have, m_re, m_de, m_rs, m_ds;

    always #5 clk = ~clk;

    lcode_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_data(sym_data),
        .clr_err(clr_err), .run_err(run_err), .disp_err(disp_err),
        .run_err_sticky(run_err_sticky), .disp_err_sticky(disp_err_sticky),
        .run_len(run_len), .disparity(disparity),
        .sym_count(sym_count), .viol_count(viol_count)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "run_err", int'(run_err), int'(m_re));
        chk(tag, "disp_err", int'(disp_err), int'(m_de));
        chk(tag, "run_err_sticky", int'(run_err_sticky), int'(m_rs));
        chk(tag, "disp_err_sticky", int'(disp_err_sticky), int'(m_ds));
        chk(tag, "run_len", int'(run_len), m_run);
        chk(tag, "disparity", int'(disparity), m_disp);
        chk(tag, "sym_count", int'(sym_count), m_sc);
        chk(tag, "viol_count", int'(viol_count), m_vc);
    endtask

    task automatic model_reset();
        m_last = 0; m_run = 0; m_prev = 0; m_disp = 0; m_sc = 0; m_vc = 0;
        m_have = 0; m_re = 0; m_de = 0; m_rs = 0; m_ds = 0;
    endtask

    // Drive one cycle; vld selects a symbol, clr the clear input
    task automatic cycle(input bit vld, input logic [9:0] d, input bit clr, input string tag);
        int dsym, w;
        bit hit, have_eff;
        sym_vld = vld; sym_data = d; clr_err = clr;
        if (vld) begin
            hit = 0;
            for (int i = 0; i < 10; i++) begin
                if (m_run != 0 && int'(d[i]) == m_last) begin
                    if (m_run < 15) m_run++;
                end else m_run = 1;
                m_last = int'(d[i]);
                if (m_run >= 6) hit = 1;
            end
            dsym = 0;
            for (int i = 0; i < 10; i++) dsym += d[i] ? 1 : -1;
            have_eff = m_have && !clr;
            w = have_eff ? dsym + m_prev : dsym;
            m_re = hit;
            m_de = have_eff && (w > 2 || w < -2);
            m_disp = w; m_prev = dsym; m_have = 1;
            if (m_sc < 65535) m_sc++;
            if ((m_re || m_de) && m_vc < 65535) m_vc++;
        end else begin
            m_re = 0; m_de = 0;
            if (clr) m_have = 0;
        end
        m_rs = (m_rs && !clr) || m_re;
        m_ds = (m_ds && !clr) || m_de;
        @(negedge clk);
        sym_vld = 1'b0; clr_err = 1'b0;
        check_all(tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        sym_data = 10'h3FF;
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
    endtask

    task automatic t_alternating();
        for (int k = 0; k < 4; k++) cycle(1, 10'h155, 0, "R10_alt");
        chk("R2", "run_len alt", int'(run_len), 1);
        chk("R4", "disparity alt", int'(disparity), 0);
    endtask

    task automatic t_paired();
        for (int k = 0; k < 3; k++) begin
            cycle(1, 10'h333, 0, "R10_pair");
            cycle(1, 10'h0CC, 0, "R10_pair");
        end
        chk("R10", "no run flag", int'(run_err_sticky), 0);
        chk("R10", "no disp flag", int'(disp_err_sticky), 0);
        cycle(1, 10'h155, 0, "R5_edge2");
        cycle(1, 10'h333, 0, "R5_edge2");
        chk("R5", "window +2 passes", int'(disp_err), 0);
        cycle(1, 10'h333, 0, "R5_over");
        chk("R5", "window +4 flagged", int'(disp_err), 1);
        chk("R4", "window +4 value", int'(disparity), 4);
    endtask

    task automatic t_boundary_run();
        cycle(0, 10'h000, 1, "R8_clr");
        cycle(1, 10'h3AA, 0, "R3_tail");
        cycle(1, 10'h153, 0, "R3_five");
        chk("R3", "run of 5 passes", int'(run_err), 0);
        cycle(1, 10'h3AA, 0, "R3_tail");
        cycle(1, 10'h157, 0, "R3_six");
        chk("R3", "run of 6 across boundary", int'(run_err), 1);
    endtask

    task automatic t_zeros();
        cycle(0, 10'h000, 1, "R8_clr");
        chk("R7", "sticky cleared", int'(run_err_sticky), 0);
        cycle(1, 10'h000, 0, "R3_zero");
        chk("R5", "first after clear exempt", int'(disp_err), 0);
        chk("R4", "single symbol value", int'(disparity), -10);
        cycle(1, 10'h000, 0, "R2_sat");
        chk("R2", "saturated run", int'(run_len), 15);
        chk("R5", "window -20 flagged", int'(disp_err), 1);
    endtask

    task automatic t_idle();
        for (int k = 0; k < 4; k++) cycle(0, 10'(k * 97 + 5), 0, "R6_idle");
        cycle(1, 10'h155, 0, "R6_resume");
    endtask

    task automatic t_clear_with_symbol();
        cycle(1, 10'h000, 1, "R7_clr_viol");
        chk("R7", "set despite clear", int'(run_err_sticky), 1);
        chk("R8", "symbol with clear is first", int'(disp_err), 0);
        cycle(1, 10'h155, 0, "R8_after");
    endtask

    initial begin
        t_reset();
        t_alternating();
        t_paired();
        t_boundary_run();
        t_zeros();
        t_idle();
        t_clear_with_symbol();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule